// File: doc/BRIEF.md
# Synchronous Answer-to-Reset Generator

This block produces the fixed identification header that a memory card shifts out when its host pulses the reset pin. The host holds chip select low and raises the reset pin. A write cycle must not be in progress. When the reset pin falls, the block starts to drive the serial data line. It sends a 32-bit header one bit at a time, and each falling edge of the serial clock moves the line to the next bit.

The header is four bytes, `19h`, `55h`, `AAh` and `55h`, sent in that order, and each byte goes out least significant bit first. The block drives the line only while the header is in flight. It releases the line after the last bit, or at once when chip select rises or the write-busy flag is raised. All pin inputs pass through a synchronizer clocked by the system clock. The header word and the synchronizer depth are parameters.

Top module: `atr_gen`

## Requirements
- R1: After the asynchronous reset `rst_ni`, `sda_oe_o` and `sda_o` are both 0.
- R2: A rising edge on `atr_rst_i` while `cs_ni` is 0 and `wr_busy_i` is 0 arms the block. The following falling edge of `atr_rst_i` sets `sda_oe_o` to 1 with `sda_o` showing header bit b1. b1 is bit 0 of byte `19h`, so it is 1.
- R3: A rising edge on `atr_rst_i` while `cs_ni` is 1 or `wr_busy_i` is 1 starts nothing. `sda_oe_o` stays 0, also through the following serial clock pulses.
- R4: The 32 bits go out as b1 to b32, taken from bytes `19h`, `55h`, `AAh`, `55h` in that order, least significant bit first. Bit bk is bit k-1 of the word `32'h55AA5519`. Each falling edge of `scl_i` advances the output by one bit.
- R5: A rising edge of `scl_i` leaves `sda_o` unchanged.
- R6: The falling edge of `scl_i` that follows b32 releases the line: `sda_oe_o` goes to 0 and `sda_o` to 0.
- R7: `cs_ni` going to 1 during the response releases the line. The block stays released after `cs_ni` returns to 0, until a new reset pulse.
- R8: `wr_busy_i` going to 1 during the response releases the line in the same way.
- R9: A new reset pulse during a response restarts the header from b1.
- R10: While `atr_rst_i` is held high after arming, `sda_oe_o` stays 0.
- R11: Each pin change takes effect at the outputs within `SYNC_STAGES`+2 cycles of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| atr_rst_i | input | 1 | Card reset pin |
| cs_ni | input | 1 | Chip select, active low |
| scl_i | input | 1 | Serial clock pin |
| wr_busy_i | input | 1 | Nonvolatile write cycle in progress |
| sda_o | output | 1 | Serial data bit (0 when not driven) |
| sda_oe_o | output | 1 | Output enable for the data line |

## Verification
The hardest case to reach from the ports is an abort or a new reset pulse that lands deep inside the header, for example after bit 30 rather than after bit 1. Only there can a stale bit counter or a shift register that was not reloaded show itself. The stimulus draws a random abort point between 1 and 32 bits and a random abort cause: chip select, write busy, a fresh reset pulse, or none. After an abort, the bench keeps clocking the serial line to show that the block stays released. After a restart, it checks the whole header again from b1.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } atr_state_e;

  localparam int unsigned HDR_BITS_DEF = 32;
  localparam logic [HDR_BITS_DEF-1:0] HDR_WORD_DEF = 32'h55AA5519;
endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] ff_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[s] <= RST_VAL;
        else         ff_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q[s] <= RST_VAL;
        else         ff_q[s] <= ff_q[s-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/atr_shifter.sv
module atr_shifter #(
  parameter int unsigned HDR_BITS = 32,
  parameter logic [HDR_BITS-1:0] HDR_WORD = 32'h55AA5519,
  localparam int unsigned CNT_W = $clog2(HDR_BITS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic shift_i,
  output logic bit_o,
  output logic last_o
);
  logic [HDR_BITS-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= HDR_WORD;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_o  = sh_q[0];
  assign last_o = (cnt_q == CNT_W'(HDR_BITS - 1));

  // R4: next bit comes from the neighbouring position (LSB first)
  a_r4_lsb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (bit_o == $past(sh_q[1])));
  // R9: a load always presents b1 of the header
  a_r9_reload_b1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (bit_o == HDR_WORD[0] && !last_o));
endmodule

// File: rtl/atr_ctrl.sv
module atr_ctrl
  import atr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_pin_i,
  input  logic cs_n_i,
  input  logic scl_i,
  input  logic busy_i,
  input  logic last_i,
  output logic load_o,
  output logic shift_o,
  output logic active_o
);
  atr_state_e state_q, state_d;
  logic rst_prev_q, scl_prev_q;
  logic rst_rise, rst_fall, scl_fall, abort;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      rst_prev_q <= 1'b0;
      scl_prev_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      rst_prev_q <= rst_pin_i;
      scl_prev_q <= scl_i;
    end
  end

  assign rst_rise = rst_pin_i & ~rst_prev_q;
  assign rst_fall = ~rst_pin_i & rst_prev_q;
  assign scl_fall = ~scl_i & scl_prev_q;
  assign abort    = cs_n_i | busy_i;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (!abort && rst_rise) begin
        state_d = ST_ARMED;
        load_o  = 1'b1;
      end
      ST_ARMED: begin
        if (abort)         state_d = ST_IDLE;
        else if (rst_fall) state_d = ST_SEND;
      end
      ST_SEND: begin
        if (abort) state_d = ST_IDLE;
        else if (rst_rise) begin
          state_d = ST_ARMED;
          load_o  = 1'b1;
        end else if (scl_fall) begin
          if (last_i) state_d = ST_IDLE;
          else        shift_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign active_o = (state_q == ST_SEND);

  // R2: driving starts only right after the reset pin fell
  a_r2_start_on_rst_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> ($past(rst_prev_q) && !$past(rst_pin_i)));
  // R6: clocking past the last bit releases the line
  a_r6_release_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && scl_fall && last_i) |=> !active_o);
  // R7: chip select high forces release
  a_r7_cs_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !active_o);
  // R8: write busy forces release
  a_r8_busy_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !active_o);
  // R10: never driving while the reset pin is high
  a_r10_quiet_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_i |=> !active_o);
endmodule

// File: rtl/atr_gen.sv
module atr_gen #(
  parameter int unsigned HDR_BITS    = atr_pkg::HDR_BITS_DEF,
  parameter logic [HDR_BITS-1:0] HDR_WORD = atr_pkg::HDR_WORD_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic atr_rst_i,
  input  logic cs_ni,
  input  logic scl_i,
  input  logic wr_busy_i,
  output logic sda_o,
  output logic sda_oe_o
);
  localparam int unsigned NPIN = 4;
  // order: {busy, scl, cs_n, rst}; chip select resets deselected
  localparam logic [NPIN-1:0] PIN_RST = 4'b0010;

  logic [NPIN-1:0] pins_s;
  logic load, shift, active, last, hbit;

  atr_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_busy_i, scl_i, cs_ni, atr_rst_i}),
    .q_o   (pins_s)
  );

  atr_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rst_pin_i(pins_s[0]),
    .cs_n_i   (pins_s[1]),
    .scl_i    (pins_s[2]),
    .busy_i   (pins_s[3]),
    .last_i   (last),
    .load_o   (load),
    .shift_o  (shift),
    .active_o (active)
  );

  atr_shifter #(.HDR_BITS(HDR_BITS), .HDR_WORD(HDR_WORD)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .bit_o  (hbit),
    .last_o (last)
  );

  assign sda_oe_o = active;
  assign sda_o    = active & hbit;

  // R1: undriven line reads as 0
  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sda_oe_o |-> !sda_o);
endmodule

// File: tb/atr_gen_tb_top.sv
module atr_gen_tb_top;
  localparam logic [31:0] HDR = 32'h55AA5519;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic atr_rst = 1'b0, cs_n = 1'b1, scl = 1'b0, busy = 1'b0;
  logic sda, sda_oe;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  atr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .atr_rst_i(atr_rst), .cs_ni(cs_n),
    .scl_i(scl), .wr_busy_i(busy), .sda_o(sda), .sda_oe_o(sda_oe)
  );

  function automatic logic hdr_bit(int k);
    return HDR[k];
  endfunction

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act={oe,sda}=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic scl_fall_edge();
    scl = 1'b1; settle();
    scl = 1'b0; settle();
  endtask

  task automatic rst_pulse();
    atr_rst = 1'b1; settle();
    chk("R10", {sda_oe, sda}, 2'b00);
    atr_rst = 1'b0; settle();
  endtask

  // clock out bits b2..b(n) after b1 has been checked
  task automatic run_bits(int n);
    for (int k = 1; k < n; k++) begin
      scl = 1'b1; settle();
      chk("R5", {sda_oe, sda}, {1'b1, hdr_bit(k-1)});
      scl = 1'b0; settle();
      chk("R4", {sda_oe, sda}, {1'b1, hdr_bit(k)});
    end
  endtask

  task automatic start_resp();
    rst_pulse();
    chk("R2", {sda_oe, sda}, {1'b1, hdr_bit(0)});
  endtask

  task automatic full_resp();
    run_bits(32);
    scl_fall_edge();
    chk("R6", {sda_oe, sda}, 2'b00);
  endtask

  task automatic stay_off(string req);
    scl_fall_edge();
    chk(req, {sda_oe, sda}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", {sda_oe, sda}, 2'b00);
    rst_n = 1'b1;
    cs_n = 1'b0;
    settle();
    chk("R1", {sda_oe, sda}, 2'b00);

    // directed: full header
    start_resp();
    full_resp();
    stay_off("R6");

    // R3: deselected at reset pulse
    cs_n = 1'b1; rst_pulse(); cs_n = 1'b0; settle();
    chk("R3", {sda_oe, sda}, 2'b00);
    stay_off("R3");
    // R3: busy at reset pulse
    busy = 1'b1; rst_pulse(); busy = 1'b0; settle();
    chk("R3", {sda_oe, sda}, 2'b00);
    stay_off("R3");

    // R11: latency bound, first bit visible within SYNC_STAGES+2 cycles
    atr_rst = 1'b1; settle();
    atr_rst = 1'b0; repeat (4) @(negedge clk);
    chk("R11", {sda_oe, sda}, {1'b1, hdr_bit(0)});
    full_resp();

    // random aborts and restarts
    for (int it = 0; it < 24; it++) begin
      int n    = $urandom_range(1, 32);
      int mode = $urandom_range(0, 3);
      start_resp();
      run_bits(n);
      case (mode)
        0: begin
          run_bits(33 - n + 1 > 1 ? 1 : 1);
          // finish the header from the current bit
          for (int k = n; k < 32; k++) begin
            scl_fall_edge();
            chk("R4", {sda_oe, sda}, {1'b1, hdr_bit(k)});
          end
          scl_fall_edge();
          chk("R6", {sda_oe, sda}, 2'b00);
        end
        1: begin
          cs_n = 1'b1; settle();
          chk("R7", {sda_oe, sda}, 2'b00);
          cs_n = 1'b0; settle();
          chk("R7", {sda_oe, sda}, 2'b00);
          stay_off("R7");
        end
        2: begin
          busy = 1'b1; settle();
          chk("R8", {sda_oe, sda}, 2'b00);
          busy = 1'b0; settle();
          stay_off("R8");
        end
        default: begin
          rst_pulse();
          chk("R9", {sda_oe, sda}, {1'b1, hdr_bit(0)});
          full_resp();
        end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule